// File: doc/BRIEF.md
# Gated Prescaled 16/32-bit Timer Pair

Two up-counting timers, A and B, share one register port. Each timer has its own control word, period register and count register. Each timer counts a selected event source through a divider with four ratios. The source is either every system clock cycle or the rising edges of an external pin. With the internal source, counting can be limited to the time a gate pin is high. When the count reaches the period value, the next tick returns it to zero and a one-cycle match pulse is raised.

A control bit in timer A joins the two timers into one 32-bit counter. Timer B then holds the upper half and ignores its own control word. An idle input can freeze either timer when that timer's halt-in-idle bit is set. The external clock and gate pins are synchronized inside the block before any edge or level on them is used.

Register map (3-bit address): 0 control A, 1 control B, 2 period A, 3 period B, 4 count A, 5 count B, 6 and 7 read 0. Control word bits: [0] run, [1] halt in idle, [2] gate enable, [4:3] divide select, [5] external source, [6] join into 32 bits (timer A only).

Top module: `tmr_pair`

## Requirements
- R1: After reset, both control words and both counts read 0, both periods read 0xFFFF, and all match and gate-done outputs are 0.
- R2: Control A reads back only bits [6:0] and control B reads back only bits [5:0]; every other control bit reads 0, and addresses 6 and 7 read 0.
- R3: With run=1, the internal source, gating off and divide select 00, the count rises by one on every clock edge at which run was already 1.
- R4: Divide select 00, 01, 10 and 11 advance the count once per 1, 8, 64 and 256 qualified events.
- R5: When the count equals the period and a tick occurs, the count returns to 0. The match output is high for exactly that following cycle, in which the count reads 0.
- R6: A write to a count address loads that count, and the load takes priority over counting.
- R7: With the external source selected, each rising edge on the external pin produces one event, after a two-flop synchronizer and edge detector.
- R8: With the gate enabled and the internal source selected, events are counted only while the synchronized gate is high. With the external source selected, the gate enable has no effect.
- R9: In gated internal mode, a falling edge of the synchronized gate while run=1 raises gate-done for one cycle.
- R10: With halt-in-idle=1, the count holds while idle is high. With halt-in-idle=0, counting continues through idle.
- R11: Any write to a timer's control word clears that timer's prescale counter.
- R12: With the join bit set, {count B, count A} form one 32-bit counter. It is driven by timer A's control and compared against {period B, period A}. Timer B's control is ignored, and match B and gate-done B stay 0.
- R13: With run=0, the count holds except when it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the internal source counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| idle | input | 1 | Idle-mode indication |
| ext_clk_a | input | 1 | External count pin, timer A (also for the joined counter) |
| ext_clk_b | input | 1 | External count pin, timer B |
| gate_a | input | 1 | Gate pin, timer A (also for the joined counter) |
| gate_b | input | 1 | Gate pin, timer B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| cnt_a | output | 16 | Count of timer A (low half when joined) |
| cnt_b | output | 16 | Count of timer B (high half when joined) |
| match_a | output | 1 | Period match pulse, timer A or the joined counter |
| match_b | output | 1 | Period match pulse, timer B |
| gate_done_a | output | 1 | Gate fall pulse, timer A |
| gate_done_b | output | 1 | Gate fall pulse, timer B |

## Verification
The bound checker checks these rules on every cycle:
- the count either holds, steps by one, or returns to zero;
- the count freezes while stopped or halted in idle;
- a match only appears while the count reads zero;
- gate-done never lasts two cycles;
- timer B stays silent while joined;
- the control B readback mask holds.

Only the bench's scenarios can show the exact counts:
- the number of events reached under each divide ratio;
- how many wraps match pulses report;
- the latency of the external-pin and gate synchronizers;
- the prescaler reset on a control rewrite;
- the carry across the 32-bit join.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_BITS = 7;
  localparam int AW = 3;

  typedef struct packed {
    logic       join32;
    logic       ext_src;
    logic [1:0] div_sel;
    logic       gate_on;
    logic       idle_halt;
    logic       run;
  } ctl_t;

  localparam logic [AW-1:0] ADR_CTL_A = 3'd0;
  localparam logic [AW-1:0] ADR_CTL_B = 3'd1;
  localparam logic [AW-1:0] ADR_PRD_A = 3'd2;
  localparam logic [AW-1:0] ADR_PRD_B = 3'd3;
  localparam logic [AW-1:0] ADR_CNT_A = 3'd4;
  localparam logic [AW-1:0] ADR_CNT_B = 3'd5;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign lvl  = sh_q[1];
  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       evt,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic [PW-1:0] lim;
  logic          pre_en;

  always_comb begin
    lim    = PW'((32'd1 << (3 * int'(div_sel))) - 32'd1);
    tick   = evt && (pre_q == lim);
    pre_en = clr | evt;
    if (clr)       pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         wrap,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld | wrap | inc;
    if (ld)        cnt_d = ld_val;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idle,
  input  logic         ext_clk_a,
  input  logic         ext_clk_b,
  input  logic         gate_a,
  input  logic         gate_b,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         match_a,
  output logic         match_b,
  output logic         gate_done_a,
  output logic         gate_done_b
);
  import tmr_pkg::*;

  localparam int NCH = 2;
  localparam int PW  = 8;
  localparam int CB  = CTL_BITS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ctl_t           ctl_q [NCH];
  ctl_t           ctl_d [NCH];
  logic [W-1:0]   prd_q [NCH];
  logic [W-1:0]   cnt   [NCH];
  logic [NCH-1:0] ctl_we, prd_we, ld;
  logic [NCH-1:0] ext_pin, gate_pin;
  logic [NCH-1:0] ext_rise, gate_lvl, gate_fall;
  logic [NCH-1:0] evt, tick, inc, wrap;
  logic [NCH-1:0] mt_d, mt_q, gd_d, gd_q;
  logic           joined;
  logic [CB-1:0]  ctl_a_bits;

  assign ext_pin  = {ext_clk_b, ext_clk_a};
  assign gate_pin = {gate_b, gate_a};
  assign joined   = ctl_q[0].join32;
  assign ctl_a_bits = ctl_q[0];

  // write decode and next control values
  always_comb begin
    ctl_we[0] = wr_en && (wr_addr == ADR_CTL_A);
    ctl_we[1] = wr_en && (wr_addr == ADR_CTL_B);
    prd_we[0] = wr_en && (wr_addr == ADR_PRD_A);
    prd_we[1] = wr_en && (wr_addr == ADR_PRD_B);
    ld[0]     = wr_en && (wr_addr == ADR_CNT_A);
    ld[1]     = wr_en && (wr_addr == ADR_CNT_B);
    ctl_d[0]  = ctl_t'(wr_data[CB-1:0]);
    ctl_d[1]  = ctl_t'(wr_data[CB-1:0]);
    ctl_d[1].join32 = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int i = 0; i < NCH; i++) begin
        ctl_q[i] <= '0;
        prd_q[i] <= '1;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ctl_we[i]) ctl_q[i] <= ctl_d[i];
        if (prd_we[i]) prd_q[i] <= wr_data;
      end
    end
  end

  // per-channel event path
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic unused_ext_lvl, unused_ext_fall, unused_gate_rise;
    logic live, gate_ok;

    tmr_sync_edge u_ext (
      .clk(clk), .rst_n(rst_i), .pin(ext_pin[g]),
      .lvl(unused_ext_lvl), .rise(ext_rise[g]), .fall(unused_ext_fall)
    );
    tmr_sync_edge u_gate (
      .clk(clk), .rst_n(rst_i), .pin(gate_pin[g]),
      .lvl(gate_lvl[g]), .rise(unused_gate_rise), .fall(gate_fall[g])
    );

    assign live    = ctl_q[g].run && !(ctl_q[g].idle_halt && idle);
    assign gate_ok = !ctl_q[g].gate_on || ctl_q[g].ext_src || gate_lvl[g];
    assign evt[g]  = live && gate_ok && (ctl_q[g].ext_src ? ext_rise[g] : 1'b1);

    tmr_prescale #(.PW(PW)) u_pre (
      .clk(clk), .rst_n(rst_i), .clr(ctl_we[g]), .evt(evt[g]),
      .div_sel(ctl_q[g].div_sel), .tick(tick[g])
    );

    tmr_half #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_i), .ld(ld[g]), .ld_val(wr_data),
      .wrap(wrap[g]), .inc(inc[g]), .cnt(cnt[g])
    );

    assign gd_d[g] = gate_fall[g] && ctl_q[g].run && ctl_q[g].gate_on &&
                     !ctl_q[g].ext_src && !(g == 1 && joined);
  end

  // counting: independent halves or one joined counter
  always_comb begin
    if (joined) begin
      wrap[0] = tick[0] && ({cnt[1], cnt[0]} == {prd_q[1], prd_q[0]});
      wrap[1] = wrap[0];
      inc[0]  = tick[0];
      inc[1]  = tick[0] && (&cnt[0]);
      mt_d[0] = wrap[0] && !ld[0] && !ld[1];
      mt_d[1] = 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        wrap[i] = tick[i] && (cnt[i] == prd_q[i]);
        inc[i]  = tick[i];
        mt_d[i] = wrap[i] && !ld[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mt_q <= '0;
      gd_q <= '0;
    end else begin
      mt_q <= mt_d;
      gd_q <= gd_d;
    end
  end

  // read port
  always_comb begin
    case (rd_addr)
      ADR_CTL_A: rd_data = {{(W-CB){1'b0}}, ctl_q[0]};
      ADR_CTL_B: rd_data = {{(W-CB){1'b0}}, ctl_q[1]};
      ADR_PRD_A: rd_data = prd_q[0];
      ADR_PRD_B: rd_data = prd_q[1];
      ADR_CNT_A: rd_data = cnt[0];
      ADR_CNT_B: rd_data = cnt[1];
      default:   rd_data = '0;
    endcase
  end

  assign cnt_a       = cnt[0];
  assign cnt_b       = cnt[1];
  assign match_a     = mt_q[0];
  assign match_b     = mt_q[1];
  assign gate_done_a = gd_q[0];
  assign gate_done_b = gd_q[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         idle,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [2:0]   rd_addr,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] cnt_a,
  input logic         match_a,
  input logic         match_b,
  input logic         gate_done_a,
  input logic         gate_done_b,
  input logic [6:0]   ctl_a_bits
);
  logic load_a;
  assign load_a = wr_en && (wr_addr == 3'd4);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_a |=> (cnt_a == $past(cnt_a)) || (cnt_a == W'($past(cnt_a) + 1'b1)) || (cnt_a == '0));

  // R13
  run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_a_bits[0] && !load_a) |=> $stable(cnt_a));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_a_bits[0] && ctl_a_bits[1] && idle && !load_a) |=> $stable(cnt_a));

  // R5
  match_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |-> (cnt_a == '0));

  // R9
  gate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_done_a |=> !gate_done_a);

  // R12
  joined_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_a_bits[6] |=> (!match_b && !gate_done_b));

  // R2
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd1) |-> ((rd_data >> 6) == '0));
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .cnt_a(cnt_a), .match_a(match_a),
  .match_b(match_b), .gate_done_a(gate_done_a), .gate_done_b(gate_done_b),
  .ctl_a_bits(ctl_a_bits)
);

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;
  localparam int RUN = 1, HALT = 2, GATE = 4, EXT = 32, JOIN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b0, ext_clk_a = 1'b0, ext_clk_b = 1'b0, gate_a = 1'b0, gate_b = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, cnt_a, cnt_b;
  logic match_a, match_b, gate_done_a, gate_done_b;

  int total = 0, bad = 0;
  int ma = 0, mb = 0, ga = 0;
  bit done = 0;

  tmr_pair dut (
    .clk(clk), .rst_n(rst_n), .idle(idle), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
    .gate_a(gate_a), .gate_b(gate_b), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .match_a(match_a), .match_b(match_b), .gate_done_a(gate_done_a), .gate_done_b(gate_done_b)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (match_a) ma++;
    if (match_b) mb++;
    if (gate_done_a) ga++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  function automatic int exp_cnt(int events, int div, int prd);
    return (events / div) % (prd + 1);
  endfunction

  function automatic int exp_wraps(int events, int div, int prd);
    return (events / div) / (prd + 1);
  endfunction

  // run for k extra cycles: k+1 qualified internal events
  task automatic timed_run(logic [2:0] ca, logic [15:0] cv, int k);
    wr(ca, cv | RUN);
    repeat (k) @(negedge clk);
    wr(ca, cv & ~16'(RUN));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctl_a", v, 0);
    rd(3'd1, v); chk("R1 ctl_b", v, 0);
    rd(3'd2, v); chk("R1 prd_a", v, 16'hFFFF);
    rd(3'd3, v); chk("R1 prd_b", v, 16'hFFFF);
    chk("R1 counts", {cnt_b, cnt_a}, 0);
    chk("R1 flags", {match_a, match_b, gate_done_a, gate_done_b}, 0);

    // R2 readback masks
    wr(3'd0, 16'hFF80); rd(3'd0, v); chk("R2 ctl_a upper", v, 0);
    wr(3'd1, 16'hFFFF); rd(3'd1, v); chk("R2 ctl_b mask", v, 16'h003F);
    wr(3'd1, 16'h0000);
    rd(3'd6, v); chk("R2 addr6", v, 0);

    // R6 load
    wr(3'd5, 16'h1234); rd(3'd5, v); chk("R6 load b", v, 16'h1234);

    // R3 plain 1:1 count, R13 hold when stopped
    wr(3'd4, 0);
    timed_run(3'd0, 0, 19);
    chk("R3 count 20", cnt_a, 20);
    repeat (10) @(negedge clk);
    chk("R13 hold", cnt_a, 20);

    // R4 divide ratios
    wr(3'd4, 0); timed_run(3'd0, 16'h0010, 255); chk("R4 1:64", cnt_a, 4);
    wr(3'd4, 0); timed_run(3'd0, 16'h0018, 255); chk("R4 1:256", cnt_a, 1);
    wr(3'd4, 0); timed_run(3'd0, 16'h0018, 254); chk("R4 1:256 short", cnt_a, 0);
    wr(3'd4, 0); timed_run(3'd0, 16'h0008, 23);  chk("R4 1:8", cnt_a, 3);

    // R11 control rewrite clears the prescaler
    wr(3'd4, 0);
    wr(3'd0, 16'h0008 | RUN);
    repeat (4) @(negedge clk);
    wr(3'd0, 16'h0008 | RUN);
    repeat (6) @(negedge clk);
    wr(3'd0, 16'h0008);
    chk("R11 prescaler cleared", cnt_a, 0);

    // R10 idle
    wr(3'd4, 0);
    idle = 1'b1;
    timed_run(3'd0, HALT, 29);
    chk("R10 halted in idle", cnt_a, 0);
    timed_run(3'd0, 0, 9);
    chk("R10 runs through idle", cnt_a, 10);
    idle = 1'b0;

    // R8 R9 gated accumulation
    wr(3'd4, 0);
    ga = 0;
    wr(3'd0, GATE | RUN);
    repeat (10) @(negedge clk);
    chk("R8 gate low no count", cnt_a, 0);
    gate_a = 1'b1;
    repeat (20) @(negedge clk);
    gate_a = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 gated count", cnt_a, 20);
    chk("R9 gate done pulses", ga, 1);
    wr(3'd0, 0);

    // R7 external edges, R8 gate ignored with external source
    wr(3'd4, 0);
    wr(3'd0, EXT | GATE | RUN);
    for (int i = 0; i < 7; i++) begin
      ext_clk_a = 1'b1; repeat (3) @(negedge clk);
      ext_clk_a = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(3'd0, 0);
    chk("R7 ext edges", cnt_a, 7);
    chk("R8 gate ignored ext", cnt_a, 7);

    // R5 match timing: period 3, 1:1, 9 events -> 2 wraps, count 1
    wr(3'd2, 3); wr(3'd4, 0);
    ma = 0;
    timed_run(3'd0, 0, 8);
    chk("R5 count", cnt_a, exp_cnt(9, 1, 3));
    chk("R5 wraps", ma, exp_wraps(9, 1, 3));

    // random runs on both timers
    for (int it = 0; it < 24; it++) begin
      int ch, p, dsel, div, k;
      logic [2:0] ca, pa, na;
      ch = int'($urandom % 2);
      p = int'($urandom % 50);
      dsel = int'($urandom % 2);
      div = dsel ? 8 : 1;
      k = int'($urandom % 400);
      ca = ch ? 3'd1 : 3'd0;
      pa = ch ? 3'd3 : 3'd2;
      na = ch ? 3'd5 : 3'd4;
      wr(pa, 16'(p)); wr(na, 0);
      ma = 0; mb = 0;
      timed_run(ca, 16'(dsel * 8), k);
      @(negedge clk);
      chk("R5 R4 random count", ch ? cnt_b : cnt_a, exp_cnt(k + 1, div, p));
      chk("R5 random wraps", ch ? mb : ma, exp_wraps(k + 1, div, p));
    end

    // R12 joined counter: 32-bit period compare, B control ignored
    wr(3'd0, JOIN);
    wr(3'd1, 16'h0018 | RUN);
    wr(3'd2, 16'h0005); wr(3'd3, 16'h0001);
    wr(3'd4, 16'h0003); wr(3'd5, 16'h0001);
    ma = 0; mb = 0;
    timed_run(3'd0, JOIN, 4);
    @(negedge clk);
    chk("R12 joined wrap", {cnt_b, cnt_a}, 32'h0000_0002);
    chk("R12 joined match a", ma, 1);
    chk("R12 match b quiet", mb, 0);
    // carry from low to high half
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'hFFFE); wr(3'd5, 16'h0002);
    timed_run(3'd0, JOIN, 4);
    chk("R12 carry", {cnt_b, cnt_a}, 32'h0003_0003);
    rd(3'd1, v); chk("R12 ctl_b kept", v, 16'h0019);
    wr(3'd1, 0); wr(3'd0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule